// File: doc/BRIEF.md
# Synchronous Microprocessor Register Port

This block is a slave port through which an external processor reads and writes a small bank of control and status registers over a synchronous parallel bus. The processor supplies the clock, and every input is sampled on its rising edge. The block has an active-low chip select, an active-low write strobe and an active-low output enable. The data bus is bidirectional. It runs 8 bits wide after reset. Software can widen it to 16 bits at run time, and the register window then changes from 128 byte locations to 64 halfword locations.

A write is accepted only when the write strobe is sampled high, then low, then high on three consecutive edges. The address and data used are the ones captured on the edge where the strobe was low. Behind the register window sit a control word driven out to the surrounding logic, a read-only status word taken in from it, a sticky interrupt status register with an enable mask, and a 16-entry data buffer. The surrounding logic fills the buffer in read mode and drains it in write mode. Two outputs are driven from this state: a buffer-ready flag and a level interrupt request.

Top module: `mpu_regport`

## Requirements
- R1: The address is captured on each rising edge where `cs_n` is low. The read data for that address is registered on the same edge, so it appears on the pins after that edge and no earlier.
- R2: `data` is driven only while both `cs_n` and `oe_n` are low. `oe_n` takes effect without waiting for a clock edge. Otherwise the pins are high-impedance.
- R3: A write commits only if `we_n` is sampled 1, 0, 1 on three consecutive edges, with `cs_n` low on the edge where `we_n` is 0. A strobe held low for two edges, or one whose low edge sees `cs_n` high, changes nothing.
- R4: After reset the bus is 8 bits wide. Bit 0 of halfword 0 selects the 16-bit width when set.
- R5: In 8-bit mode, `addr[0]` selects the low byte (0) or high byte (1) of halfword `addr[6:1]`. The byte travels on `data[7:0]` and `data[15:8]` stays high-impedance. In 16-bit mode, `addr[0]` is ignored.
- R6: The halfword map is as follows. Halfword 0 is the mode register: bit 0 is width, bit 1 is buffer direction (1 = write mode), bit 2 is interrupt enable. Halfword 1 is the control word on `ctrl_out`. Halfword 2 is `stat_in`; writes to it are ignored. Halfword 3 is the interrupt status, halfword 4 is the interrupt mask and halfword 5 is the data buffer. Every other halfword reads 0.
- R7: A high `irq_src` bit sets the matching status bit. The bit stays set until a write of 1 to that position. Writing 0 leaves it set.
- R8: `irq` is high exactly when the interrupt enable bit is set and some status bit is set whose mask bit is also set. It is low whenever the interrupt enable bit is clear.
- R9: In read mode, `buf_rdy` is high when the buffer is not empty. In write mode, it is high when the buffer is not full.
- R10: In read mode, a processor read of halfword 5 returns the oldest entry and removes it. In 8-bit mode only the high-byte read removes the entry. A read of the empty buffer returns 0 and removes nothing.
- R11: In write mode, a write to halfword 5 appends an entry. In 8-bit mode the low byte is held until the high-byte write appends both. Writes to a full buffer are ignored. Processor reads in write mode return 0 and remove nothing.
- R12: `bk_push` appends `bk_din` in read mode unless the buffer is full. `bk_pop` removes the entry shown on `bk_dout` in write mode unless the buffer is empty. Each is ignored in the other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-supplied clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 7 | Byte address |
| data | inout | 16 | Bidirectional data bus |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low output enable |
| buf_rdy | output | 1 | Data buffer ready |
| irq | output | 1 | Interrupt request, active high |
| ctrl_out | output | 16 | Control word to surrounding logic |
| stat_in | input | 16 | Status word from surrounding logic |
| irq_src | input | NSRC | Interrupt source pulses |
| bk_push | input | 1 | Surrounding logic appends to buffer |
| bk_din | input | 16 | Entry appended by surrounding logic |
| bk_pop | input | 1 | Surrounding logic removes from buffer |
| bk_dout | output | 16 | Oldest buffer entry |

## Verification
The bench stretches the write strobe low over two edges and moves the chip select away from the low edge. A design that commits on a bare low level or on any falling edge would then alter the control word. It pushes the buffer one entry past full from each side and reads it empty afterwards. A design with wrong full or empty guards would overwrite the last entry or return a stale one. In 8-bit mode it reads and writes the buffer low byte on its own. A design that pops or pushes on either byte would lose half an entry or duplicate one. It also raises output enable in mid-cycle and reads status bits that were cleared with the wrong pattern. A clocked output enable, or a status register that clears on any write, shows up as the wrong pin value or the wrong status bit.

// File: rtl/mpu_regport.sv
module mpu_regport #(
  parameter int NSRC  = 8,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      addr,
  inout  wire  [15:0]     data,
  input  logic            cs_n,
  input  logic            we_n,
  input  logic            oe_n,
  output logic            buf_rdy,
  output logic            irq,
  output logic [15:0]     ctrl_out,
  input  logic [15:0]     stat_in,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bk_push,
  input  logic [15:0]     bk_din,
  input  logic            bk_pop,
  output logic [15:0]     bk_dout
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [6:0]      addr_q;
  logic [15:0]     din_q, rdata_q, rv;
  logic            we_s1, we_s2, cs_s1;
  logic            wide, dir, gie;
  logic [15:0]     ctrl_q;
  logic [NSRC-1:0] isr, ier;
  logic [7:0]      stage;
  logic [15:0]     mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  wire [5:0]  widx   = addr_q[6:1];
  wire [5:0]  ridx   = addr[6:1];
  wire        commit = we_n & ~we_s1 & we_s2 & cs_s1;
  wire        full   = (cnt == CW'(DEPTH));
  wire        empty  = (cnt == '0);
  wire [15:0] wmask  = wide ? 16'hFFFF : (addr_q[0] ? 16'hFF00 : 16'h00FF);
  wire [15:0] wval   = wide ? din_q : {din_q[7:0], din_q[7:0]};
  wire [15:0] mode16 = {13'b0, gie, dir, wide};
  wire [15:0] ier16  = 16'(ier);
  wire [15:0] n_mode = (mode16 & ~wmask) | (wval & wmask);
  wire [15:0] n_ctrl = (ctrl_q & ~wmask) | (wval & wmask);
  wire [15:0] n_ier  = (ier16 & ~wmask) | (wval & wmask);
  wire [15:0] clr    = (commit && widx == 6'd3) ? (wval & wmask) : 16'h0;
  wire        lane_hi_w = wide | addr_q[0];
  wire        h_push = commit && widx == 6'd5 && dir && !full && lane_hi_w;
  wire        h_pop  = !cs_n && !oe_n && ridx == 6'd5 && !dir && !empty && (wide | addr[0]);
  wire        push   = dir ? h_push : (bk_push && !full);
  wire        pop    = dir ? (bk_pop && !empty) : h_pop;
  wire [15:0] pdata  = dir ? (wide ? din_q : {din_q[7:0], stage}) : bk_din;
  wire        drive  = !cs_n && !oe_n;

  always_comb begin
    case (ridx)
      6'd0:    rv = mode16;
      6'd1:    rv = ctrl_q;
      6'd2:    rv = stat_in;
      6'd3:    rv = 16'(isr);
      6'd4:    rv = ier16;
      6'd5:    rv = (!dir && !empty) ? mem[rp] : 16'h0;
      default: rv = 16'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0; din_q <= '0; rdata_q <= '0;
      we_s1 <= 1'b1; we_s2 <= 1'b1; cs_s1 <= 1'b0;
      wide <= 1'b0; dir <= 1'b0; gie <= 1'b0;
      ctrl_q <= '0; isr <= '0; ier <= '0; stage <= '0;
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      din_q <= data;
      we_s1 <= we_n;
      we_s2 <= we_s1;
      cs_s1 <= !cs_n;
      if (!cs_n) begin
        addr_q  <= addr;
        rdata_q <= wide ? rv : {8'h00, addr[0] ? rv[15:8] : rv[7:0]};
      end
      isr <= (isr & ~clr[NSRC-1:0]) | irq_src;
      if (commit) begin
        case (widx)
          6'd0: {gie, dir, wide} <= n_mode[2:0];
          6'd1: ctrl_q <= n_ctrl;
          6'd4: ier <= n_ier[NSRC-1:0];
          6'd5: if (!wide && !addr_q[0]) stage <= din_q[7:0];
          default: ;
        endcase
      end
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= pdata;

  assign data[7:0]  = drive ? rdata_q[7:0] : {8{1'bz}};
  assign data[15:8] = (drive && wide) ? rdata_q[15:8] : {8{1'bz}};
  assign ctrl_out   = ctrl_q;
  assign bk_dout    = mem[rp];
  assign buf_rdy    = dir ? !full : !empty;
  assign irq        = gie && |(isr & ier);
endmodule

// File: rtl/mpu_regport_chk.sv
module mpu_regport_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [6:0]               addr,
  input logic                     cs_n,
  input logic                     we_n,
  input logic [15:0]              ctrl_out,
  input logic                     irq,
  input logic [6:0]               addr_q,
  input logic                     commit,
  input logic                     wide,
  input logic [$clog2(DEPTH):0]   cnt
);
  assert_addr_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> addr_q == $past(addr));

  assert_write_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl_out) |-> ($past(we_n, 1) && !$past(we_n, 2) && $past(we_n, 3)));

  assert_width_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide) |-> $past(commit));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(commit));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ($clog2(DEPTH) + 1)'(DEPTH));

  assert_single_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) || (cnt + 1'b1 == $past(cnt)));
endmodule

bind mpu_regport mpu_regport_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n), .we_n(we_n),
  .ctrl_out(ctrl_out), .irq(irq), .addr_q(addr_q), .commit(commit),
  .wide(wide), .cnt(cnt)
);

// File: tb/mpu_regport_test.sv
module mpu_regport_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] addr = '0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic buf_rdy, irq;
  logic [15:0] ctrl_out, bk_dout;
  logic [15:0] stat_in = 16'hC35A;
  logic [7:0]  irq_src = '0;
  logic bk_push = 1'b0, bk_pop = 1'b0;
  logic [15:0] bk_din = '0;
  logic [15:0] tbv = '0;
  logic tben = 1'b0;
  wire  [15:0] data;
  int checks = 0, fails = 0;

  assign data = tben ? tbv : {16{1'bz}};
  for (genvar i = 0; i < 16; i++) begin : g_pu
    pullup (data[i]);
  end

  always #5 clk = ~clk;

  mpu_regport uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .data(data), .cs_n(cs_n),
    .we_n(we_n), .oe_n(oe_n), .buf_rdy(buf_rdy), .irq(irq),
    .ctrl_out(ctrl_out), .stat_in(stat_in), .irq_src(irq_src),
    .bk_push(bk_push), .bk_din(bk_din), .bk_pop(bk_pop), .bk_dout(bk_dout)
  );

  // {write, addr, value}; reads in 8-bit mode expect 8'hFF on the floating upper lane
  localparam logic [23:0] VEC [12] = '{
    {1'b1, 7'h02, 16'h0034}, {1'b1, 7'h03, 16'h0012},
    {1'b0, 7'h02, 16'h0034}, {1'b0, 7'h03, 16'h0012},
    {1'b1, 7'h08, 16'h00FF}, {1'b0, 7'h08, 16'h00FF},
    {1'b0, 7'h09, 16'h0000}, {1'b0, 7'h0E, 16'h0000},
    {1'b1, 7'h04, 16'h00AA}, {1'b0, 7'h04, 16'h005A},
    {1'b0, 7'h05, 16'h00C3}, {1'b0, 7'h00, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_seq(input logic [6:0] a, input logic [15:0] d, input int lowc, input bit cs_low);
    @(negedge clk); cs_n = 1'b0; addr = a; tbv = d; tben = 1'b1; we_n = 1'b1;
    repeat (lowc) begin
      @(negedge clk); we_n = 1'b0; cs_n = !cs_low;
    end
    @(negedge clk); we_n = 1'b1; cs_n = 1'b0;
    @(negedge clk); cs_n = 1'b1; tben = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    wr_seq(a, d, 1, 1'b1);
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] v);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; addr = a;
    @(negedge clk); v = data; cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_src(input logic [7:0] s);
    @(negedge clk); irq_src = s;
    @(negedge clk); irq_src = '0;
  endtask

  task automatic bpush(input logic [15:0] d);
    @(negedge clk); bk_push = 1'b1; bk_din = d;
    @(negedge clk); bk_push = 1'b0;
  endtask

  task automatic bpop();
    @(negedge clk); bk_pop = 1'b1;
    @(negedge clk); bk_pop = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 reset ctrl_out", ctrl_out, 16'h0000);
    chk("R8 reset irq", {15'b0, irq}, 16'h0);
    chk("R9 reset buf_rdy", {15'b0, buf_rdy}, 16'h0);
    chk("R2 idle pins", data, 16'hFFFF);
    rd(7'h00, v); chk("R4 reset mode 8-bit", v, 16'hFF00);

    foreach (VEC[i]) begin
      if (VEC[i][23]) wr(VEC[i][22:16], VEC[i][15:0]);
      else begin
        rd(VEC[i][22:16], v);
        chk($sformatf("R6/R5 vector %0d", i), v, {8'hFF, VEC[i][7:0]});
      end
    end
    chk("R6 ctrl_out", ctrl_out, 16'h1234);

    wr_seq(7'h02, 16'h0099, 2, 1'b1);
    chk("R3 long low ignored", ctrl_out, 16'h1234);
    wr_seq(7'h02, 16'h0099, 1, 1'b0);
    chk("R3 cs high on low edge ignored", ctrl_out, 16'h1234);

    wr(7'h00, 16'h0001);
    rd(7'h02, v); chk("R4 16-bit read", v, 16'h1234);
    rd(7'h03, v); chk("R5 addr0 ignored wide", v, 16'h1234);

    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0; addr = 7'h04;
    #1 chk("R1 old data before edge", data, 16'h1234);
    @(negedge clk); chk("R1 new data after edge", data, 16'hC35A);
    #1 oe_n = 1'b1;
    #1 chk("R2 async oe high", data, 16'hFFFF);
    oe_n = 1'b0; cs_n = 1'b1;
    #1 chk("R2 cs high", data, 16'hFFFF);
    oe_n = 1'b1;

    pulse_src(8'h08);
    chk("R8 gie off", {15'b0, irq}, 16'h0);
    rd(7'h06, v); chk("R7 status set", v, 16'h0008);
    wr(7'h00, 16'h0005);
    chk("R8 gie on", {15'b0, irq}, 16'h1);
    wr(7'h06, 16'h0001);
    rd(7'h06, v); chk("R7 wrong bit keeps", v, 16'h0008);
    chk("R7 irq held", {15'b0, irq}, 16'h1);
    wr(7'h06, 16'h0008);
    chk("R7 cleared irq", {15'b0, irq}, 16'h0);
    wr(7'h08, 16'h0000);
    pulse_src(8'h02);
    chk("R8 masked", {15'b0, irq}, 16'h0);
    wr(7'h08, 16'h0002);
    chk("R8 unmasked", {15'b0, irq}, 16'h1);
    wr(7'h00, 16'h0001);
    chk("R8 gie cleared", {15'b0, irq}, 16'h0);
    wr(7'h06, 16'hFFFF);

    chk("R9 read mode empty", {15'b0, buf_rdy}, 16'h0);
    rd(7'h0A, v); chk("R10 empty read", v, 16'h0000);
    bpush(16'hBEEF);
    chk("R9 read mode data", {15'b0, buf_rdy}, 16'h1);
    bpop();
    chk("R12 bk_pop ignored in read mode", {15'b0, buf_rdy}, 16'h1);
    rd(7'h0A, v); chk("R10 pop", v, 16'hBEEF);
    chk("R10 empty after pop", {15'b0, buf_rdy}, 16'h0);
    for (int i = 0; i < 17; i++) bpush(16'h0100 + 16'(i));
    for (int i = 0; i < 16; i++) begin
      rd(7'h0A, v); chk("R12 fill order", v, 16'h0100 + 16'(i));
    end
    rd(7'h0A, v); chk("R12 extra push dropped", v, 16'h0000);

    wr(7'h00, 16'h0003);
    chk("R9 write mode room", {15'b0, buf_rdy}, 16'h1);
    for (int i = 0; i < 17; i++) wr(7'h0A, 16'h0200 + 16'(i));
    chk("R9 write mode full", {15'b0, buf_rdy}, 16'h0);
    rd(7'h0A, v); chk("R11 read in write mode", v, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      chk("R11 drain order", bk_dout, 16'h0200 + 16'(i));
      bpop();
    end
    wr(7'h00, 16'h0001);
    chk("R11 extra write dropped", {15'b0, buf_rdy}, 16'h0);

    wr(7'h00, 16'h0002);
    wr(7'h0A, 16'h0034);
    wr(7'h0B, 16'h0012);
    chk("R11 byte pair push", bk_dout, 16'h1234);
    bpop();
    wr(7'h00, 16'h0000);
    chk("R11 single entry", {15'b0, buf_rdy}, 16'h0);

    bpush(16'hCAFE);
    rd(7'h0A, v); chk("R10 low byte", v, 16'hFFFE);
    chk("R10 low byte keeps entry", {15'b0, buf_rdy}, 16'h1);
    rd(7'h0B, v); chk("R10 high byte", v, 16'hFFCA);
    chk("R10 high byte pops", {15'b0, buf_rdy}, 16'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule